// File: doc/BRIEF.md
# Digital Quadrature Upconverter

This block takes two baseband sample streams, in-phase (I) and quadrature (Q), and places them onto a digital carrier at the system clock rate. It produces one real output sample per clock, which can drive a DAC directly. The carrier comes from an internal phase accumulator. A tuning word, loaded through a one-cycle write strobe, is added to the accumulator on every clock. The top bits of the phase address a sine table. The same table, read a quarter turn ahead, gives the cosine.

I is multiplied by the cosine and Q by the sine. The two products are added and rounded. The sum is then scaled by half of full amplitude. Because of this halving, full-scale I and Q on both inputs can never exceed the output word, at the price of a 3 dB net loss. A valid flag travels alongside the data through the three register stages.

Top module: `qmod_upconv`

## Requirements
- R1: A synchronous reset clears the phase accumulator and the tuning register to zero, and drives `out_valid` and `out_sample` to 0. The first sample after reset uses phase 0.
- R2: On each clock edge out of reset, the phase becomes the old phase plus the tuning register, modulo 2^32. The lookup address is the phase's top 10 bits (31:22).
- R3: Sine table entry k equals round-half-away-from-zero of 2047·sin(2πk/1024), for k in 0..1023.
- R4: The cosine is the table entry at address (a + 256) mod 1024, where a is the sine address taken from the same phase.
- R5: `out_sample` = saturate12((I·cos + Q·sin + 2048) >>> 12). The arithmetic is signed two's complement and the shift is arithmetic.
- R6: A sample presented before clock edge k appears on `out_sample` after edge k+2. It uses the phase value held before edge k. `out_valid` carries `in_valid` with the same delay.
- R7: When `ftw_wr` is high before edge k, `ftw_data` is stored at edge k and is first added to the phase at edge k+1. The phase is not reset.
- R8: Full-scale inputs (−2048 on I and Q) never overflow, and `out_sample` never equals −2048.
- R9: The phase wraps modulo 2^32, so a tuning word above 2^31 steps the carrier backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one output sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ftw_wr | input | 1 | Write strobe for the tuning word |
| ftw_data | input | 32 | Tuning word value to load |
| in_valid | input | 1 | Marks the I/Q pair as valid |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| out_valid | output | 1 | Delayed copy of `in_valid` |
| out_sample | output | 12 | Modulated real sample, signed |

## Verification
The bench builds the block with its default parameters: 12-bit data and amplitude, a 32-bit phase and a 1024-entry table. With these values every table address can be reached, and full-scale inputs of −2048 can drive the sum to its largest magnitude, which exercises the rounding and saturation edge. Tuning words of exactly a quarter or an eighth of a turn land on fixed table points, so the cosine offset is checked at known angles. A step of 0xFFC00000 walks the phase backwards through the zero wrap. Random tuning words give odd phase increments, and random writes land at arbitrary points in the pipeline.

// File: rtl/qmod_pkg.sv
package qmod_pkg;
    localparam real PI_C = 3.141592653589793;

    // Rounded sine value for table index k, used to build the ROM at elaboration
    function automatic int sine_entry(input int k, input int depth, input int amp_w);
        real amp;
        real r;
        amp = real'((1 << (amp_w - 1)) - 1);
        r   = amp * $sin(2.0 * PI_C * real'(k) / real'(depth));
        if (r >= 0.0)
            return $rtoi(r + 0.5);
        else
            return -$rtoi(-r + 0.5);
    endfunction
endpackage

// File: rtl/qmod_phase_acc.sv
module qmod_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ftw_wr,
    input  logic [PHASE_W-1:0] ftw_data,
    output logic [PHASE_W-1:0] ftw_q,
    output logic [PHASE_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_q <= '0;
            phase <= '0;
        end else begin
            phase <= phase + ftw_q;
            if (ftw_wr)
                ftw_q <= ftw_data;
        end
    end
endmodule

// File: rtl/qmod_sincos_rom.sv
module qmod_sincos_rom #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] sin_q,
    output logic signed [AMP_W-1:0] cos_q
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(DEPTH / 4);

    logic signed [AMP_W-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        localparam int VAL = qmod_pkg::sine_entry(k, DEPTH, AMP_W);
        assign table_w[k] = AMP_W'(VAL);
    end

    logic [ADDR_W-1:0] cos_addr;
    assign cos_addr = addr + QUARTER;

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            sin_q <= table_w[addr];
            cos_q <= table_w[cos_addr];
        end
    end
endmodule

// File: rtl/qmod_mix.sv
module qmod_mix #(
    parameter int IQ_W  = 12,
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IQ_W-1:0]  in_i,
    input  logic signed [IQ_W-1:0]  in_q,
    input  logic signed [AMP_W-1:0] sin_s1,
    input  logic signed [AMP_W-1:0] cos_s1,
    output logic                    out_valid,
    output logic signed [IQ_W-1:0]  out_sample
);
    localparam int PROD_W = IQ_W + AMP_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam int SHIFT  = AMP_W;
    localparam int SH_W   = SUM_W - SHIFT;
    localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) << (SHIFT - 1);
    localparam logic signed [SH_W-1:0]  OUT_MAX  = SH_W'((1 << (IQ_W - 1)) - 1);
    localparam logic signed [SH_W-1:0]  OUT_MIN  = -OUT_MAX - SH_W'(1);

    logic signed [IQ_W-1:0]   i_s1, q_s1;
    logic                     v_s1, v_s2;
    logic signed [PROD_W-1:0] pi_s2, pq_s2;
    logic signed [SUM_W-1:0]  sum_c;
    logic signed [SH_W-1:0]   shr_c;
    logic signed [IQ_W-1:0]   sat_c;

    always_comb begin
        sum_c = SUM_W'(pi_s2) + SUM_W'(pq_s2) + HALF_LSB;
        shr_c = SH_W'(sum_c >>> SHIFT);
        if (shr_c > OUT_MAX)
            sat_c = IQ_W'(OUT_MAX);
        else if (shr_c < OUT_MIN)
            sat_c = IQ_W'(OUT_MIN);
        else
            sat_c = IQ_W'(shr_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_s1       <= '0;
            q_s1       <= '0;
            v_s1       <= 1'b0;
            pi_s2      <= '0;
            pq_s2      <= '0;
            v_s2       <= 1'b0;
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            i_s1       <= in_i;
            q_s1       <= in_q;
            v_s1       <= in_valid;
            pi_s2      <= i_s1 * cos_s1;
            pq_s2      <= q_s1 * sin_s1;
            v_s2       <= v_s1;
            out_sample <= sat_c;
            out_valid  <= v_s2;
        end
    end
endmodule

// File: rtl/qmod_upconv.sv
module qmod_upconv #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int IQ_W    = 12,
    parameter int AMP_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ftw_wr,
    input  logic [PHASE_W-1:0]     ftw_data,
    input  logic                   in_valid,
    input  logic signed [IQ_W-1:0] in_i,
    input  logic signed [IQ_W-1:0] in_q,
    output logic                   out_valid,
    output logic signed [IQ_W-1:0] out_sample
);
    logic [PHASE_W-1:0]      ftw_q;
    logic [PHASE_W-1:0]      phase;
    logic signed [AMP_W-1:0] sin_s1, cos_s1;

    qmod_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ftw_wr   (ftw_wr),
        .ftw_data (ftw_data),
        .ftw_q    (ftw_q),
        .phase    (phase)
    );

    qmod_sincos_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk   (clk),
        .rst   (rst),
        .addr  (phase[PHASE_W-1 -: ADDR_W]),
        .sin_q (sin_s1),
        .cos_q (cos_s1)
    );

    qmod_mix #(.IQ_W(IQ_W), .AMP_W(AMP_W)) u_mix (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_i       (in_i),
        .in_q       (in_q),
        .sin_s1     (sin_s1),
        .cos_s1     (cos_s1),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/qmod_upconv_chk.sv
module qmod_upconv_chk #(
    parameter int PHASE_W = 32,
    parameter int IQ_W    = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ftw_wr,
    input logic [PHASE_W-1:0]     ftw_data,
    input logic                   in_valid,
    input logic                   out_valid,
    input logic signed [IQ_W-1:0] out_sample,
    input logic [PHASE_W-1:0]     phase,
    input logic [PHASE_W-1:0]     ftw_q
);
    localparam logic signed [IQ_W-1:0] MOST_NEG = {1'b1, {(IQ_W-1){1'b0}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == '0 && ftw_q == '0 && !out_valid)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase == $past(phase) + $past(ftw_q)); // R2
    AST_VALID_EARLY: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd3) |-> !out_valid); // R6
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3)); // R6
    AST_FTW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ftw_wr)) |-> ftw_q == $past(ftw_data)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_sample != MOST_NEG); // R8
endmodule

bind qmod_upconv qmod_upconv_chk #(.PHASE_W(PHASE_W), .IQ_W(IQ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ftw_wr     (ftw_wr),
    .ftw_data   (ftw_data),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .phase      (phase),
    .ftw_q      (ftw_q)
);

// File: tb/qmod_upconv_test.sv
module qmod_upconv_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ftw_wr = 1'b0;
    logic [31:0] ftw_data = '0;
    logic        in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic        out_valid;
    logic signed [11:0] out_sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_tag = "R5";

    logic [31:0] ph_m, ftw_m;
    bit          ev [3];
    int          ed [3];

    always #2 clk = ~clk;

    qmod_upconv uut (
        .clk(clk), .rst(rst), .ftw_wr(ftw_wr), .ftw_data(ftw_data),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int sin_tab(input int k);
        real r;
        r = 2047.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 1024.0);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic int model_out(input int i, input int q, input logic [31:0] ph);
        int a, s, c;
        longint acc;
        a = int'(ph[31:22]);
        s = sin_tab(a);
        c = sin_tab((a + 256) % 1024);
        acc = longint'(i) * c + longint'(q) * s + 2048;
        acc = acc >>> 12;
        if (acc > 2047) acc = 2047;
        if (acc < -2048) acc = -2048;
        return int'(acc);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic cycle(input bit v, input int i, input int q, input bit wr, input logic [31:0] wd);
        in_valid = v;
        in_i     = 12'(i);
        in_q     = 12'(q);
        ftw_wr   = wr;
        ftw_data = wd;
        ev[2] = ev[1]; ed[2] = ed[1];
        ev[1] = ev[0]; ed[1] = ed[0];
        ev[0] = v;     ed[0] = model_out(i, q, ph_m);
        @(posedge clk);
        ph_m = ph_m + ftw_m;
        if (wr) ftw_m = wd;
        @(negedge clk);
        check("R6", int'(out_valid), int'(ev[2]));
        if (ev[2]) check(cur_tag, int'(out_sample), ed[2]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ph_m = '0; ftw_m = '0;
        for (int k = 0; k < 3; k++) begin ev[k] = 1'b0; ed[k] = 0; end
        repeat (5) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sample), 0);
        rst = 1'b0;
        // R1: first sample at phase 0 -> cos full scale, sin zero
        cur_tag = "R1";
        cycle(1, 1000, 500, 0, '0);
        cycle(1, -1000, 2047, 0, '0);
        cycle(0, 0, 0, 0, '0);
        // R7: quarter-turn step, write then next clock uses it
        cur_tag = "R7";
        cycle(1, 700, -300, 1, 32'h4000_0000);
        cycle(1, 700, -300, 0, '0);
        cycle(1, 700, -300, 0, '0);
        // R4: quarter-turn positions hit exact table points for cosine offset
        cur_tag = "R4";
        for (int n = 0; n < 8; n++) cycle(1, 1500, 900, 0, '0);
        // R8: eighth-turn step with full-scale negative inputs
        cur_tag = "R8";
        cycle(1, -2048, -2048, 1, 32'h2000_0000);
        for (int n = 0; n < 16; n++) cycle(1, -2048, -2048, 0, '0);
        for (int n = 0; n < 16; n++) cycle(1, 2047, 2047, 0, '0);
        // R9: backward stepping through the zero wrap
        cur_tag = "R9";
        cycle(1, 1200, 1200, 1, 32'hFFC0_0000);
        for (int n = 0; n < 40; n++) cycle(1, 1200, -800, 0, '0);
        // R2 / R3: fine step sweeps every table address
        cur_tag = "R3";
        cycle(1, 2047, 0, 1, 32'h0040_0000);
        for (int n = 0; n < 1100; n++) cycle(1, 2047, -2048 + n % 4096, 0, '0);
        cur_tag = "R2";
        cycle(1, 333, 1777, 1, 32'h0123_4567);
        for (int n = 0; n < 300; n++) cycle(1, 333, 1777, 0, '0);
        // R5: random stimulus with random tuning writes and gaps
        cur_tag = "R5";
        for (int n = 0; n < 5000; n++) begin
            bit wr = ($urandom % 16) == 0;
            bit v  = ($urandom % 4) != 0;
            int i  = int'($urandom % 4096) - 2048;
            int q  = int'($urandom % 4096) - 2048;
            cycle(v, i, q, wr, $urandom);
        end
        // drain the pipeline
        for (int n = 0; n < 4; n++) cycle(0, 0, 0, 0, '0);
        finish_run();
    end

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule